// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block runs a self-offset calibration on the output word stream of a decimating converter. A calibration is armed by a low-to-high transition of the calibration request. It starts on the next SYNC event and counts valid output words while the decimation filter settles. The word that follows the settling period is taken as the offset sample: it is passed out unchanged, a one-cycle done pulse marks it, and it is written into the offset register.

Outside a calibration, the stored offset can be subtracted from each output word when the use-offset enable is high. The difference saturates at the limits of the signed word. With the enable low, words pass through unchanged and the register keeps its value for later use. After a calibration has finished, a new one needs a short handshake. The request and SYNC must both be low for at least one clock, then the request rises, then SYNC is given again. A request that stays high therefore yields a single calibration.

Top module: `offset_cal_sequencer`

## Requirements
- R1: After reset the offset register is zero, `out_vld` and `cal_done` are low, `out_word` is zero, and with `use_ofs` high words pass through unchanged.
- R2: A calibration is armed only by a rising edge of `cal_req` that follows a clock in which `cal_req` and `sync_in` were both low. It starts only when `sync_in` is high in a later clock. A rising edge with no SYNC, or with no earlier low/low clock, starts nothing.
- R3: The first `SETTLE_WORDS` (default 56) valid words after the start are passed out raw, whatever `use_ofs` and the stored offset are, and `cal_done` stays low for them.
- R4: The next valid word, the 57th by default, is passed out raw with `cal_done` high for exactly that one output cycle, and it becomes the stored offset.
- R5: Outside a calibration with `use_ofs` = 1, `out_word` = `word_in` − offset.
- R6: With `use_ofs` = 0 words pass unchanged. The offset register keeps its value, so setting `use_ofs` back to 1 applies the old offset again.
- R7: The subtraction saturates to [−2^(W−1), 2^(W−1)−1] and does not wrap.
- R8: While `cal_req` stays high after a calibration, later SYNC pulses start no new calibration.
- R9: The restart sequence (both low for one clock, request high, then SYNC) starts a new calibration that replaces the stored offset.
- R10: `out_vld` follows `word_vld` with exactly one clock of latency, and `out_word` belongs to that word. `cal_done` is never high without `out_vld`.
- R11: SYNC pulses that arrive during a calibration do not restart the word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Calibration request level |
| sync_in | input | 1 | SYNC event, sampled as a level |
| use_ofs | input | 1 | Apply the stored offset to words |
| word_vld | input | 1 | Input word strobe |
| word_in | input | W | Signed input word |
| out_word | output | W | Corrected or raw output word |
| out_vld | output | 1 | Output word strobe |
| cal_done | output | 1 | Pulse marking the offset sample |

## Verification
Every word result appears one clock after its input strobe is sampled, because the correction stage is a single register. A done pulse lands in the same output cycle as the 57th counted word. A SYNC or request edge takes effect at the clock edge that samples it, so it changes which words after it are raw. The driver presents each word at a falling edge and pushes its expected value and done bit into a queue. The monitor compares at every falling edge on which `out_vld` is high, one cycle after the push, so each compare uses a value settled by the preceding rising edge.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  typedef enum logic [0:0] {
    CS_IDLE = 1'b0,
    CS_RUN  = 1'b1
  } cal_state_e;
endpackage

// File: rtl/ocal_arm.sv
module ocal_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic sync_in,
  input  logic idle,
  output logic armed,
  output logic start
);
  logic req_q;
  logic primed_q;
  logic armed_q;
  logic arm_evt;

  // a rising request edge counts only after a low/low clock, and only while idle
  assign arm_evt = idle && primed_q && cal_req && !req_q;
  assign start   = armed_q && sync_in && idle;
  assign armed   = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      primed_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      req_q <= cal_req;
      if (!cal_req && !sync_in) primed_q <= 1'b1;
      else if (arm_evt)         primed_q <= 1'b0;
      if (start)        armed_q <= 1'b0;
      else if (arm_evt) armed_q <= 1'b1;
    end
  end

  // R2: arming comes only from a request rising edge
  a_r2_arm_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(cal_req) && !$past(req_q));
endmodule

// File: rtl/ocal_count.sv
module ocal_count #(
  parameter int SETTLE_WORDS = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic word_vld,
  output logic running,
  output logic cap
);
  import ocal_pkg::*;
  localparam int CW = $clog2(SETTLE_WORDS + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_WORDS);

  cal_state_e    st_q;
  logic [CW-1:0] cnt_q;

  assign running = (st_q == CS_RUN);
  assign cap     = running && word_vld && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        CS_IDLE: if (start) begin
          st_q  <= CS_RUN;
          cnt_q <= '0;
        end
        CS_RUN: if (word_vld) begin
          if (cnt_q == LAST) st_q <= CS_IDLE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  // R3: the settle count never passes its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4: capturing the offset sample ends the calibration
  a_r4_cap_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !running);
endmodule

// File: rtl/ocal_correct.sv
module ocal_correct #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_vld,
  input  logic signed [W-1:0] word_in,
  input  logic                use_ofs,
  input  logic                running,
  input  logic                cap,
  output logic signed [W-1:0] out_word,
  output logic                out_vld,
  output logic                cal_done
);
  localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sat_sub(
    input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    logic signed [W:0] d;
    d = {a[W-1], a} - {b[W-1], b};
    if (d[W] != d[W-1]) return d[W] ? S_MIN : S_MAX;
    return d[W-1:0];
  endfunction

  logic signed [W-1:0] ofs_q;
  logic signed [W-1:0] nxt_word;
  logic                apply;

  assign apply    = use_ofs && !running;
  assign nxt_word = apply ? sat_sub(word_in, ofs_q) : word_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q    <= '0;
      out_word <= '0;
      out_vld  <= 1'b0;
      cal_done <= 1'b0;
    end else begin
      out_vld  <= word_vld;
      cal_done <= cap;
      if (word_vld) out_word <= nxt_word;
      if (cap)      ofs_q    <= word_in;
    end
  end

  // R6: the offset register changes only on a capture
  a_r6_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(ofs_q));
  // R4: the captured word is the raw sample
  a_r4_ofs_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> ofs_q == $past(word_in));
endmodule

// File: rtl/offset_cal_sequencer.sv
module offset_cal_sequencer #(
  parameter int W            = 24,
  parameter int SETTLE_WORDS = 56
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_req,
  input  logic                sync_in,
  input  logic                use_ofs,
  input  logic                word_vld,
  input  logic signed [W-1:0] word_in,
  output logic signed [W-1:0] out_word,
  output logic                out_vld,
  output logic                cal_done
);
  logic running;
  logic cap;
  logic armed;
  logic start;

  ocal_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cal_req (cal_req),
    .sync_in (sync_in),
    .idle    (!running),
    .armed   (armed),
    .start   (start)
  );

  ocal_count #(.SETTLE_WORDS(SETTLE_WORDS)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .word_vld (word_vld),
    .running  (running),
    .cap      (cap)
  );

  ocal_correct #(.W(W)) u_correct (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word_in  (word_in),
    .use_ofs  (use_ofs),
    .running  (running),
    .cap      (cap),
    .out_word (out_word),
    .out_vld  (out_vld),
    .cal_done (cal_done)
  );

  // R10: one clock of latency from input strobe to output strobe
  a_r10_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> out_vld);
  a_r10_no_extra_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> !out_vld);
  // R10: done is a pulse that comes with a word
  a_r10_done_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> out_vld);
  // R2: a calibration starts only on an armed SYNC
  a_r2_start_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(sync_in) && $past(armed));
endmodule

// File: tb/offset_cal_sequencer_bench.sv
module offset_cal_sequencer_bench;
  localparam int W = 24;
  localparam int SMAX = 8388607;
  localparam int SMIN = -8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req = 1'b0, sync_in = 1'b0, use_ofs = 1'b0, word_vld = 1'b0;
  logic signed [W-1:0] word_in = '0;
  logic signed [W-1:0] out_word;
  logic out_vld, cal_done;

  always #5 clk = ~clk;

  offset_cal_sequencer u_offset_cal_sequencer (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .sync_in(sync_in),
    .use_ofs(use_ofs), .word_vld(word_vld), .word_in(word_in),
    .out_word(out_word), .out_vld(out_vld), .cal_done(cal_done));

  typedef struct { int w; bit d; string tag; } exp_t;
  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  function automatic int sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return int'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int data, input int exp, input bit d, input string tag, input int gap);
    exp_t e;
    @(negedge clk);
    word_vld = 1'b1;
    word_in  = W'(data);
    e.w = exp; e.d = d; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    word_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  // monitor: compare every output word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (q.size() == 0) chk(1'b0, "R10 unexpected word", int'(out_word), 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(out_word) == e.w, {e.tag, " word"}, int'(out_word), e.w);
        chk(cal_done == e.d, {e.tag, " done"}, int'(cal_done), int'(e.d));
      end
    end
    if (rst_n && cal_done && !out_vld) chk(1'b0, "R10 done without word", 1, 0);
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
    chk(cal_done == 1'b0, "R1 cal_done", int'(cal_done), 0);
    chk(out_word == '0, "R1 out_word", int'(out_word), 0);
    rst_n = 1'b1;
    use_ofs = 1'b1;
    send(1234, 1234, 0, "R1", 0);
    send(-77, -77, 0, "R1", 1);
    // R2: SYNC without any request edge starts nothing
    pulse_sync();
    for (int i = 0; i < 60; i++) send(i, i, 0, "R2 no edge", 0);
    // R2: request edge alone starts nothing
    @(negedge clk); cal_req = 1'b1;
    send(5, 5, 0, "R2 edge no sync", 1);
    send(6, 6, 0, "R2 edge no sync", 0);
    pulse_sync();
    for (int i = 0; i < 56; i++) send(i * 7 - 100, i * 7 - 100, 0, "R3 settle", i % 3);
    send(1000, 1000, 1, "R4 sample", 0);
    send(1500, 500, 0, "R5", 0);
    send(-2000, -3000, 0, "R5", 2);
    send(SMIN + 5, SMIN, 0, "R7 low sat", 0);
    @(negedge clk); use_ofs = 1'b0;
    send(1500, 1500, 0, "R6 disabled", 0);
    @(negedge clk); use_ofs = 1'b1;
    send(1500, 500, 0, "R6 retained", 0);
    // R8: request held high, more SYNC pulses do nothing
    pulse_sync();
    for (int i = 0; i < 60; i++) send(5000 + i, 4000 + i, 0, "R8", 0);
    // R2: request cycled while SYNC high: no low/low clock, not armed
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    pulse_sync();
    for (int i = 0; i < 60; i++) send(-i, -i - 1000, 0, "R2 no handshake", 0);
    // R9: proper restart handshake
    @(negedge clk); cal_req = 1'b0; sync_in = 1'b0;
    @(negedge clk);
    @(negedge clk); cal_req = 1'b1;
    pulse_sync();
    for (int i = 0; i < 20; i++) send(300 + i, 300 + i, 0, "R3 R9 raw", i % 2);
    pulse_sync();  // R11: ignored mid-run
    for (int i = 20; i < 56; i++) send(300 + i, 300 + i, 0, "R11 raw", 0);
    send(-1000, -1000, 1, "R9 sample", 0);
    send(SMAX - 10, sat(longint'(SMAX - 10) + 1000), 0, "R7 high sat", 0);
    send(0, 1000, 0, "R9 new ofs", 0);
    send(-5, 995, 0, "R9 new ofs", 0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 missing words", q.size(), 0);
    finish_run();
  end
endmodule